// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block drives one pulse-width-modulated output from an 8-bit period timer. The timer counts from zero up to a programmable period value and then wraps. A 10-bit time base is formed from the timer count and two fine bits below it. The output is high at the start of each period and goes low once the time base reaches the active duty value.

The duty value is split across an 8-bit coarse input and a 2-bit fine input. Both inputs may change at any moment. They are copied into an internal active register only at the period boundary, so a period that has already started never sees a partly updated duty value.

A prescale select slows the timer by 1, 4 or 16. A one-cycle pulse marks each period boundary. A sticky flag records that a boundary has happened, which lets a controller wait out one complete period before it relies on the output.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset, `pwm`, `pmatch` and `ovf` are low. While `en` is low, the timer and fine counter hold at zero, and `pwm` and `pmatch` stay low.
- R2: The period lasts (`period`+1)×4×P clocks, where P is 1 for `pscale`=00, 4 for 01, and 16 for 10 or 11. `pmatch` is high for exactly the first clock of each new period.
- R3: With active duty value D, `pwm` is high for the first D×P clocks of the period and low for the rest. D is {`duty_hi`,`duty_lo`}, with `duty_lo` as the two LSBs.
- R4: When D is zero, `pwm` stays low for the whole period.
- R5: When D ≥ 4×(`period`+1), `pwm` stays high for the whole period.
- R6: The duty inputs are sampled only at the clock edge that ends a period. Changing them in the middle of a period leaves the current period's pulse unchanged, and the new value applies from the next period.
- R7: `ovf` is set at every period boundary and stays set until `ovf_clr` is asserted. If a boundary and `ovf_clr` fall on the same edge, the set wins.
- R8: The first period after `en` rises starts from a count of zero, so its first boundary comes (`period`+1)×4×P clocks later. The active duty value is zero after reset, so `pwm` is low throughout that first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable |
| period | input | 8 | Timer terminal count |
| duty_hi | input | 8 | Pending duty value, upper 8 bits |
| duty_lo | input | 2 | Pending duty value, lower 2 bits |
| pscale | input | 2 | Prescale select: 00=1, 01=4, 1x=16 |
| ovf_clr | input | 1 | Clears the sticky boundary flag |
| pwm | output | 1 | PWM output level |
| pmatch | output | 1 | One-clock pulse at each period start |
| ovf | output | 1 | Sticky period-boundary flag |

## Verification
The bench changes the duty inputs halfway through a period. A design without double buffering would then produce a pulse of the wrong length in that period. A zero duty value is tested, since a design that sets the output unconditionally at the boundary would emit a glitch. So is a duty value at or above the period length, where a design that wraps or truncates the comparison would drop the output too early. Each prescale setting is timed in exact clocks, which catches a fine-bit selection that is off by a factor of the prescale. The first period after enable is checked to be both full length and low, which catches a design that keeps a stale count or loads the duty value early.

// File: rtl/pwm_dbuf.sv
module pwm_dbuf #(
  parameter int TW = 8,
  parameter int FW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] period,
  input  logic [TW-1:0] duty_hi,
  input  logic [FW-1:0] duty_lo,
  input  logic [1:0]    pscale,
  input  logic          ovf_clr,
  output logic          pwm,
  output logic          pmatch,
  output logic          ovf
);
  localparam int DW = TW + FW;
  localparam int PW = FW + 4;

  logic [TW-1:0] tmr;
  logic [PW-1:0] pre, lim;
  logic [FW-1:0] fine;
  logic [DW-1:0] dact;
  logic          tick, bnd;

  always_comb begin
    case (pscale)
      2'b00:   begin lim = PW'(3);  fine = pre[1:0]; end
      2'b01:   begin lim = PW'(15); fine = pre[3:2]; end
      default: begin lim = PW'(63); fine = pre[5:4]; end
    endcase
  end

  assign tick = en && (pre >= lim);
  assign bnd  = tick && (tmr == period);
  assign pwm  = en && ({tmr, fine} < dact);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0; pre <= '0; dact <= '0; pmatch <= 1'b0; ovf <= 1'b0;
    end else begin
      pmatch <= bnd;
      if (bnd) ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      if (!en) begin
        tmr <= '0;
        pre <= '0;
      end else if (tick) begin
        pre <= '0;
        if (bnd) begin
          tmr  <= '0;
          dact <= {duty_hi, duty_lo};
        end else begin
          tmr <= tmr + 1'b1;
        end
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tmr == '0 && pre == '0) || en);
  assert_disabled_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm);
  assert_match_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pmatch |-> (tmr == '0 && pre == '0));
  assert_rise_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm) |-> (tmr == '0 && pre == '0));
  assert_zero_duty_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dact == '0) |-> !pwm);
  assert_duty_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(dact));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pmatch |-> ovf);
endmodule

// File: tb/test_pwm_dbuf.sv
module test_pwm_dbuf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] period = 8'd4;
  logic [7:0] duty_hi = 8'd0;
  logic [1:0] duty_lo = 2'd0;
  logic [1:0] pscale = 2'd0;
  logic       ovf_clr = 1'b0;
  logic       pwm, pmatch, ovf;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  pwm_dbuf i_pwm_dbuf (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .duty_hi(duty_hi),
    .duty_lo(duty_lo), .pscale(pscale), .ovf_clr(ovf_clr),
    .pwm(pwm), .pmatch(pmatch), .ovf(ovf)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic sync();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (pmatch) return;
    end
  endtask

  task automatic run_period(input int n, input int chg_at, input logic [9:0] nd,
                            output int hi, output int len_ok);
    hi = 0; len_ok = 1;
    for (int i = 0; i < n; i++) begin
      if (i > 0 && pmatch) len_ok = 0;
      if (i == chg_at) {duty_hi, duty_lo} = nd;
      if (pwm) hi++;
      @(negedge clk);
    end
    if (!pmatch) len_ok = 0;
  endtask

  task automatic setup(input logic [7:0] p, input logic [1:0] ps, input logic [9:0] d);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(!pwm && !pmatch, "R1 disabled", pwm, 0);
    period = p; pscale = ps; {duty_hi, duty_lo} = d;
    en = 1'b1;
    sync();
  endtask

  task automatic t_reset();
    check(!pwm && !pmatch && !ovf, "R1 reset", {pwm, pmatch, ovf}, 0);
  endtask

  task automatic t_first();
    int cnt = 0, hi = 0;
    period = 8'd4; pscale = 2'd0; {duty_hi, duty_lo} = 10'd7;
    @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      if (pwm) hi++;
      @(negedge clk);
      cnt++;
      if (pmatch) break;
    end
    check(cnt == 20, "R8 first len", cnt, 20);
    check(hi == 0, "R8 first low", hi, 0);
  endtask

  task automatic t_base();
    int hi, ok;
    run_period(20, -1, 10'd7, hi, ok);
    check(ok == 1, "R2 len ps1", ok, 1);
    check(hi == 7, "R3 high ps1", hi, 7);
  endtask

  task automatic t_ovf();
    check(ovf, "R7 set", ovf, 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check(!ovf, "R7 clear", ovf, 0);
    @(negedge clk);
    check(!ovf, "R7 stays clear", ovf, 0);
    sync();
    check(ovf, "R7 reset at boundary", ovf, 1);
  endtask

  task automatic t_ps(input logic [7:0] p, input logic [1:0] ps, input logic [9:0] d,
                      input int n, input int exph, input string tag);
    int hi, ok;
    setup(p, ps, d);
    run_period(n, -1, d, hi, ok);
    check(ok == 1, {"R2 len ", tag}, ok, 1);
    check(hi == exph, {"R3 high ", tag}, hi, exph);
  endtask

  task automatic t_zero();
    int hi, ok;
    setup(8'd4, 2'd0, 10'd0);
    run_period(20, -1, 10'd0, hi, ok);
    check(hi == 0, "R4 zero duty", hi, 0);
  endtask

  task automatic t_full(input logic [9:0] d);
    int hi, ok;
    setup(8'd4, 2'd0, d);
    run_period(20, -1, d, hi, ok);
    check(hi == 20, "R5 full duty", hi, 20);
  endtask

  task automatic t_dbuf();
    int hi, ok;
    setup(8'd4, 2'd0, 10'd8);
    run_period(20, 5, 10'd16, hi, ok);
    check(hi == 8, "R6 old duty kept", hi, 8);
    run_period(20, -1, 10'd16, hi, ok);
    check(hi == 16, "R6 new duty applied", hi, 16);
    run_period(20, 2, 10'd3, hi, ok);
    check(hi == 16, "R6 second change kept", hi, 16);
    run_period(20, -1, 10'd3, hi, ok);
    check(hi == 3, "R6 low bits applied", hi, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first();
    t_base();
    t_ovf();
    t_ps(8'd2, 2'd1, 10'd5, 48, 20, "ps4");
    t_ps(8'd1, 2'd2, 10'd3, 128, 48, "ps16");
    t_ps(8'd1, 2'd3, 10'd2, 128, 32, "ps16b");
    t_zero();
    t_full(10'd20);
    t_full(10'd1023);
    t_dbuf();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule